// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory DMA Engine

This block copies blocks of memory on behalf of software. Four channels each own a small window of configuration words. The words are a control word, an element count, and three 64-bit pointers: source, destination and a scatter-gather pointer that is only stored. Each pointer is written as two 32-bit halves. The engine fetches each element from the source pointer and stores it unchanged at the destination pointer, through a single-beat request/acknowledge memory master. An element is 1, 2, 4 or 8 bytes.

Either pointer may stay fixed for the whole transfer, which gives a fill from a fixed source or a drain into a fixed destination. The other case is that the pointer advances by one element after every element. Only one channel moves data at a time. When several channels are enabled at once, the engine serves the lowest-numbered one first. At the end of a transfer the engine drops the channel's enable bit and raises a per-channel done flag in a shared status word, which software clears by writing ones.

Top module: `dma4_engine`

## Requirements
- R1: After reset every configuration word and the status word read as zero, `busy` is low and `mem_req` is low.
- R2: Channel c, word w lives at offset 8*c+w. The words are w=0 control, 1 count, 2 source bits 63:32, 3 source bits 31:0, 4 destination bits 63:32, 5 destination bits 31:0, 6 scatter-gather bits 63:32, 7 scatter-gather bits 31:0. Each word reads back exactly what was last written to it.
- R3: A write to one half of a 64-bit pointer leaves the other half unchanged, and the first access of a transfer presents the full 64-bit source pointer, then the full 64-bit destination pointer.
- R4: Control bit 31 written as 1 starts the channel. Each element is one read at the source (`mem_we`=0) followed by one write at the destination (`mem_we`=1). Data sits little-endian in the low bytes of the data buses. `mem_rdata` bytes above the element width are ignored, and the same bytes of `mem_wdata` are zero.
- R5: Control bits 26:25 select the element width of 2^n bytes, and `mem_size` carries that code.
- R6: Control bit 24 set makes the destination pointer advance by the element width after each element, and bit 23 does the same for the source pointer. A clear bit keeps that pointer fixed.
- R7: Only the low 16 bits of the count word give the element count. A count of zero makes no memory access, yet the channel still completes.
- R8: On completion of channel c, control bit 31 reads as 0 with all other control bits kept, and status bit 31-c is set.
- R9: The status word at offset 0x20 clears every bit written as 1 and keeps every bit written as 0. A completion that sets a bit in the same cycle as a write that clears it leaves the bit set.
- R10: Offsets 0x21 to 0x3F read as zero, and writes to them change no channel word and no status bit.
- R11: One channel transfers at a time. Among enabled channels waiting, the lowest channel number is served first.
- R12: `busy` is high from the cycle after an enabling control write until the transfer completes. A raised `mem_req` keeps its address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe, one word per cycle |
| cfg_addr | input | 6 | Configuration word offset (read and write) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr`, combinational |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the access |
| mem_size | output | 2 | Element width code, 2^n bytes |
| mem_wdata | output | 64 | Write data, element in the low bytes |
| mem_ack | input | 1 | Access completed; read data valid in this cycle |
| mem_rdata | input | 64 | Read data, element in the low bytes |
| busy | output | 1 | A channel is enabled or a transfer is in progress |

## Verification
Two functions can fall in the same cycle: the completion that sets a channel's status bit, and a software write-one-to-clear of the status word. The bench provokes the clash by first leaving an older done flag set. It then starts a short transfer and writes all ones to the status word in every cycle while `busy` is high, so the last such write lands in the completion cycle. The expected result is that only the bit of the channel that just finished survives, and the older flag is gone. The bench also overlaps register writes to waiting channels with a running transfer, which checks the lowest-first ordering against the recorded access sequence.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int REG_W        = 32;
  localparam int PTR_W        = 64;
  localparam int BUS_W        = 64;
  localparam int BUS_BYTES    = BUS_W / 8;
  localparam int WORDS_PER_CH = 8;
  localparam int EN_BIT       = 31;
  localparam int WID_LSB      = 25;
  localparam int DINC_BIT     = 24;
  localparam int SINC_BIT     = 23;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2,
    MV_DONE  = 2'd3
  } mv_state_t;

  // byte lanes that belong to an element of 2^wsel bytes
  function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] wsel);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (k < (1 << wsel)) m[8*k +: 8] = 8'hFF;
    end
    return m;
  endfunction
endpackage

// File: rtl/dma4_chan_regs.sv
module dma4_chan_regs
  import dma4_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     word,
  input  logic [W-1:0]   wdata,
  input  logic           tc_clr,
  output logic [W-1:0]   ctrl,
  output logic [W-1:0]   count,
  output logic [2*W-1:0] src,
  output logic [2*W-1:0] dst,
  output logic [2*W-1:0] sg
);
  localparam int NPTR = 3;

  logic [W-1:0]   ctrl_q, ctrl_d;
  logic [W-1:0]   cnt_q, cnt_d;
  logic [2*W-1:0] ptr_q [NPTR];
  logic [2*W-1:0] ptr_d [NPTR];
  logic           reg_ce;

  assign reg_ce = wr_en | tc_clr;

  always_comb begin
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    for (int p = 0; p < NPTR; p++) ptr_d[p] = ptr_q[p];
    if (tc_clr) ctrl_d[EN_BIT] = 1'b0;
    if (wr_en && word == 3'd0) ctrl_d = wdata;
    if (wr_en && word == 3'd1) cnt_d = wdata;
    for (int p = 0; p < NPTR; p++) begin
      if (wr_en && word[2:1] == 2'(p + 1)) begin
        if (word[0]) ptr_d[p][W-1:0]   = wdata;
        else         ptr_d[p][2*W-1:W] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      for (int p = 0; p < NPTR; p++) ptr_q[p] <= '0;
    end else if (reg_ce) begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      for (int p = 0; p < NPTR; p++) ptr_q[p] <= ptr_d[p];
    end
  end

  assign ctrl  = ctrl_q;
  assign count = cnt_q;
  assign src   = ptr_q[0];
  assign dst   = ptr_q[1];
  assign sg    = ptr_q[2];

  // completion drops the enable unless software rewrites control that cycle
  assert_enable_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr && !(wr_en && word == 3'd0)) |=> !ctrl_q[EN_BIT]);

  // writing the upper source half keeps the lower half
  assert_half_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 3'd2) |=> (ptr_q[0][W-1:0] == $past(ptr_q[0][W-1:0])));
endmodule

// File: rtl/dma4_pick.sv
module dma4_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // the chosen channel is requesting and no lower channel is
  always_comb begin
    if (any && !$isunknown(req)) begin
      assert_lowest_first_R11: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
  import dma4_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = 16,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [IW-1:0]     go_idx,
  input  logic [PTR_W-1:0]  go_src,
  input  logic [PTR_W-1:0]  go_dst,
  input  logic [CNT_W-1:0]  go_cnt,
  input  logic [1:0]        go_wsel,
  input  logic              go_sinc,
  input  logic              go_dinc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [1:0]        mem_size,
  output logic [BUS_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic              done,
  output logic [IW-1:0]     done_idx,
  output logic              active
);
  mv_state_t          st_q, st_d;
  logic [IW-1:0]      ch_q;
  logic [PTR_W-1:0]   src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [1:0]         wsel_q;
  logic               sinc_q, dinc_q;
  logic [BUS_W-1:0]   data_q;
  logic [PTR_W-1:0]   step;
  logic               load_ce, data_ce, adv_ce;

  assign step    = PTR_W'(1) << wsel_q;
  assign load_ce = (st_q == MV_IDLE) && go;
  assign data_ce = (st_q == MV_READ) && mem_ack;
  assign adv_ce  = (st_q == MV_WRITE) && mem_ack;

  always_comb begin
    st_d   = st_q;
    src_d  = src_q;
    dst_d  = dst_q;
    left_d = left_q;
    unique case (st_q)
      MV_IDLE: begin
        if (go) st_d = (go_cnt == '0) ? MV_DONE : MV_READ;
      end
      MV_READ: begin
        if (mem_ack) st_d = MV_WRITE;
      end
      MV_WRITE: begin
        if (mem_ack) begin
          left_d = left_q - CNT_W'(1);
          if (sinc_q) src_d = src_q + step;
          if (dinc_q) dst_d = dst_q + step;
          st_d = (left_q == CNT_W'(1)) ? MV_DONE : MV_READ;
        end
      end
      MV_DONE: st_d = MV_IDLE;
      default: st_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MV_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
      wsel_q <= '0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
    end else if (load_ce) begin
      ch_q   <= go_idx;
      src_q  <= go_src;
      dst_q  <= go_dst;
      left_q <= go_cnt;
      wsel_q <= go_wsel;
      sinc_q <= go_sinc;
      dinc_q <= go_dinc;
    end else if (adv_ce) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_ce) begin
      data_q <= mem_rdata & lane_mask(wsel_q);
    end
  end

  assign mem_req   = (st_q == MV_READ) || (st_q == MV_WRITE);
  assign mem_we    = (st_q == MV_WRITE);
  assign mem_addr  = (st_q == MV_WRITE) ? dst_q : src_q;
  assign mem_size  = wsel_q;
  assign mem_wdata = data_q;
  assign done      = (st_q == MV_DONE);
  assign done_idx  = ch_q;
  assign active    = (st_q != MV_IDLE);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  assert_zero_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MV_IDLE) && go && (go_cnt == '0)) |=> (done && !mem_req));

  assert_fixed_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == MV_WRITE) && mem_ack && !sinc_q) |=> $stable(src_q));
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int CFG_AW = 6,
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [1:0]        mem_size,
  output logic [BUS_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic              busy
);
  localparam int STAT_OFS = NCH * WORDS_PER_CH;

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic              in_ch, stat_hit;
  logic [IW-1:0]     ch_sel;
  logic [2:0]        word;
  logic [REG_W-1:0]  ctrl_a [NCH];
  logic [REG_W-1:0]  cnt_a  [NCH];
  logic [PTR_W-1:0]  src_a  [NCH];
  logic [PTR_W-1:0]  dst_a  [NCH];
  logic [PTR_W-1:0]  sg_a   [NCH];
  logic [NCH-1:0]    pend, done_vec;
  logic              pick_any, mv_done, mv_active;
  logic [IW-1:0]     pick_idx, mv_idx;
  logic [REG_W-1:0]  status_q, status_d;
  logic              status_ce;

  assign in_ch    = cfg_addr < CFG_AW'(STAT_OFS);
  assign stat_hit = cfg_addr == CFG_AW'(STAT_OFS);
  assign ch_sel   = cfg_addr[3 +: IW];
  assign word     = cfg_addr[2:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma4_chan_regs #(.W(REG_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_core_n),
      .wr_en (cfg_we && in_ch && (ch_sel == IW'(i))),
      .word  (word),
      .wdata (cfg_wdata),
      .tc_clr(done_vec[i]),
      .ctrl  (ctrl_a[i]),
      .count (cnt_a[i]),
      .src   (src_a[i]),
      .dst   (dst_a[i]),
      .sg    (sg_a[i])
    );
    assign pend[i]     = ctrl_a[i][EN_BIT];
    assign done_vec[i] = mv_done && (mv_idx == IW'(i));

    assert_tc_set_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
      done_vec[i] |=> status_q[REG_W-1-i]);
  end

  dma4_pick #(.N(NCH)) u_pick (
    .req (pend),
    .any (pick_any),
    .idx (pick_idx)
  );

  dma4_mover #(.N(NCH), .CNT_W(CNT_W)) u_mover (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .go       (pick_any),
    .go_idx   (pick_idx),
    .go_src   (src_a[pick_idx]),
    .go_dst   (dst_a[pick_idx]),
    .go_cnt   (cnt_a[pick_idx][CNT_W-1:0]),
    .go_wsel  (ctrl_a[pick_idx][WID_LSB +: 2]),
    .go_sinc  (ctrl_a[pick_idx][SINC_BIT]),
    .go_dinc  (ctrl_a[pick_idx][DINC_BIT]),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_size (mem_size),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .done     (mv_done),
    .done_idx (mv_idx),
    .active   (mv_active)
  );

  // status: write-one-to-clear, completion set applied last so it wins
  assign status_ce = (cfg_we && stat_hit) || mv_done;

  always_comb begin
    status_d = status_q;
    if (cfg_we && stat_hit) status_d = status_q & ~cfg_wdata;
    for (int i = 0; i < NCH; i++) begin
      if (done_vec[i]) status_d[REG_W-1-i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    status_q <= '0;
    else if (status_ce) status_q <= status_d;
  end

  always_comb begin
    cfg_rdata = '0;
    if (in_ch) begin
      unique case (word)
        3'd0: cfg_rdata = ctrl_a[ch_sel];
        3'd1: cfg_rdata = cnt_a[ch_sel];
        3'd2: cfg_rdata = src_a[ch_sel][PTR_W-1:REG_W];
        3'd3: cfg_rdata = src_a[ch_sel][REG_W-1:0];
        3'd4: cfg_rdata = dst_a[ch_sel][PTR_W-1:REG_W];
        3'd5: cfg_rdata = dst_a[ch_sel][REG_W-1:0];
        3'd6: cfg_rdata = sg_a[ch_sel][PTR_W-1:REG_W];
        default: cfg_rdata = sg_a[ch_sel][REG_W-1:0];
      endcase
    end else if (stat_hit) begin
      cfg_rdata = status_q;
    end
  end

  assign busy = mv_active | (|pend);

  assert_busy_cover_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_req |-> busy);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_we && stat_hit && !mv_done) |=> ((status_q & $past(cfg_wdata)) == '0));

  assert_ignore_hole_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_we && !in_ch && !stat_hit && !mv_done) |=> $stable(status_q));
endmodule

// File: tb/dma4_engine_test.sv
module dma4_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        busy;

  always #5 clk = ~clk;

  dma4_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0]  mem  [256];
  logic [7:0]  emem [256];
  logic [63:0] lg_addr [1024];
  logic        lg_we   [1024];
  int          lg_n = 0;
  int          lat = 0;
  int          nb;
  logic [63:0] rv;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: acknowledges after 0..2 idle cycles, junk above the element
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat > 0) begin
        lat--;
      end else begin
        nb = 1 << mem_size;
        if (lg_n < 1024) begin
          lg_addr[lg_n] = mem_addr;
          lg_we[lg_n]   = mem_we;
        end
        lg_n++;
        if (mem_we) begin
          for (int k = 0; k < nb; k++) mem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
          chk("R4 upper write lanes zero", (nb == 8) ? 64'd0 : (mem_wdata >> (8 * nb)), 64'd0);
        end else begin
          rv = {$urandom, $urandom};
          for (int k = 0; k < nb; k++) rv[8*k +: 8] = mem[8'(mem_addr[7:0] + 8'(k))];
          mem_rdata = rv;
        end
        mem_ack = 1'b1;
        lat = $urandom % 3;
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    @(negedge clk);
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk({tag, " transfer finished"}, 64'd1, 64'd0);
  endtask

  task automatic model(input int s, input int d, input int w, input bit si, input bit di, input int n);
    logic [7:0] t [8];
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < (1 << w); k++) t[k] = emem[8'(s + k)];
      for (int k = 0; k < (1 << w); k++) emem[8'(d + k)] = t[k];
      if (si) s += (1 << w);
      if (di) d += (1 << w);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    logic [31:0] v;
    v = (32'(a) * 32'h01F3_0B07) ^ 32'h1234_5678;
    if (a % 8 == 0) v[31] = 1'b0;
    return v;
  endfunction

  task automatic snap();
    for (int i = 0; i < 256; i++) emem[i] = mem[i];
  endtask

  function automatic int diff_bytes();
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) bad++;
    return bad;
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] sh [32];
    void'($urandom(32'h5EED_0D4A));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy low", 64'(busy), 64'd0);
    chk("R1 mem_req low", 64'(mem_req), 64'd0);
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), d);
      chk("R1 word zero", 64'(d), 64'd0);
    end

    // R2 register map readback
    for (int a = 0; a < 32; a++) begin
      sh[a] = pat(a);
      wr(6'(a), sh[a]);
    end
    for (int a = 0; a < 32; a++) begin
      rd(6'(a), d);
      chk("R2 readback", 64'(d), 64'(sh[a]));
    end

    // R3 half-word updates
    wr(6'(18), 32'hDEAD_0018);
    rd(6'(18), d); chk("R3 src high new", 64'(d), 64'h0000_0000_DEAD_0018);
    rd(6'(19), d); chk("R3 src low kept", 64'(d), 64'(sh[19]));
    wr(6'(13), 32'hBEEF_000D);
    rd(6'(12), d); chk("R3 dst high kept", 64'(d), 64'(sh[12]));
    rd(6'(13), d); chk("R3 dst low new", 64'(d), 64'h0000_0000_BEEF_000D);

    // R7 zero count: no access, still completes
    wr(6'(9), 32'h5555_0000);
    lg_n = 0;
    wr(6'(8), 32'h8600_0000);
    wait_idle("R7");
    chk("R7 zero count no access", 64'(lg_n), 64'd0);
    rd(6'(8), d); chk("R8 enable cleared zero count", 64'(d), 64'h0600_0000);
    rd(6'h20, d); chk("R8 status bit ch1", 64'(d), 64'h4000_0000);

    // R10 hole offsets
    wr(6'h21, 32'hFFFF_FFFF);
    wr(6'h27, 32'hFFFF_FFFF);
    wr(6'h3F, 32'hFFFF_FFFF);
    for (int a = 6'h21; a < 64; a++) begin
      rd(6'(a), d);
      chk("R10 hole reads zero", 64'(d), 64'd0);
    end
    rd(6'h20, d); chk("R10 status untouched", 64'(d), 64'h4000_0000);
    rd(6'(0), d); chk("R10 channel word untouched", 64'(d), 64'(sh[0]));
    wr(6'h20, 32'h0000_0001);
    rd(6'h20, d); chk("R9 zero bits keep", 64'(d), 64'h4000_0000);
    wr(6'h20, 32'h4000_0000);
    rd(6'h20, d); chk("R9 one bits clear", 64'(d), 64'd0);

    // R11 priority: ch3 and ch1 enabled while ch0 runs
    wr(6'(1), 32'd12); wr(6'(2), 0); wr(6'(3), 32'h0000_0000); wr(6'(4), 0); wr(6'(5), 32'h0000_0080);
    wr(6'(9), 32'd2);  wr(6'(10), 0); wr(6'(11), 32'h0000_0040); wr(6'(12), 0); wr(6'(13), 32'h0000_00C0);
    wr(6'(25), 32'd2); wr(6'(26), 0); wr(6'(27), 32'h0000_0050); wr(6'(28), 0); wr(6'(29), 32'h0000_00D0);
    snap();
    lg_n = 0;
    wr(6'(0), 32'h8780_0000);
    chk("R12 busy after enable", 64'(busy), 64'd1);
    wr(6'(24), 32'h8180_0000);
    wr(6'(8), 32'h8180_0000);
    wait_idle("R11");
    model(8'h00, 8'h80, 3, 1'b1, 1'b1, 12);
    model(8'h40, 8'hC0, 0, 1'b1, 1'b1, 2);
    model(8'h50, 8'hD0, 0, 1'b1, 1'b1, 2);
    chk("R11 access total", 64'(lg_n), 64'd32);
    chk("R11 ch1 served before ch3", 64'(lg_addr[24][7:0]), 64'h40);
    chk("R11 ch3 served last", 64'(lg_addr[28][7:0]), 64'h50);
    chk("R11 data after ordered copies", 64'(diff_bytes()), 64'd0);
    rd(6'h20, d); chk("R8 status three done", 64'(d), 64'hD000_0000);
    chk("R12 busy low after all", 64'(busy), 64'd0);
    wr(6'h20, 32'hFFFF_FFFF);

    // R9 clash: completion and clearing write in the same cycle
    wr(6'(17), 32'd0);
    wr(6'(16), 32'h8000_0000);
    wait_idle("R9");
    rd(6'h20, d); chk("R9 older flag present", 64'(d), 64'h2000_0000);
    wr(6'(1), 32'd3);
    wr(6'(0), 32'h8180_0000);
    chk("R12 busy during clash run", 64'(busy), 64'd1);
    while (busy) begin
      cfg_addr = 6'h20; cfg_wdata = 32'hFFFF_FFFF; cfg_we = 1'b1;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    rd(6'h20, d); chk("R9 set wins over same-cycle clear", 64'(d), 64'h8000_0000);
    wr(6'h20, 32'hFFFF_FFFF);

    // random transfers R4 R5 R6 R3 R7 R8
    for (int it = 0; it < 30; it++) begin
      int c, w, n;
      bit si, di;
      logic [31:0] shi, slo, dhi, dlo, ctrl;
      logic [63:0] lastd;
      c = $urandom % 4; w = $urandom % 4; n = 1 + ($urandom % 6);
      si = 1'($urandom); di = 1'($urandom);
      shi = $urandom; slo = $urandom; dhi = $urandom; dlo = $urandom;
      ctrl = ($urandom & ~32'h8780_0000) | 32'h8000_0000 | (32'(w) << 25) |
             (32'(di) << 24) | (32'(si) << 23);
      wr(6'(8*c + 1), {16'($urandom), 16'(n)});
      wr(6'(8*c + 2), shi); wr(6'(8*c + 3), slo);
      wr(6'(8*c + 4), dhi); wr(6'(8*c + 5), dlo);
      snap();
      model(int'(slo[7:0]), int'(dlo[7:0]), w, si, di, n);
      lg_n = 0;
      wr(6'(8*c), ctrl);
      wait_idle("R4");
      chk("R4 R5 R6 copied bytes", 64'(diff_bytes()), 64'd0);
      chk("R7 count uses low 16 bits", 64'(lg_n), 64'(2*n));
      chk("R3 first read full source", lg_addr[0], {shi, slo});
      chk("R3 first write full destination", lg_addr[1], {dhi, dlo});
      chk("R4 read then write", {63'd0, lg_we[0]} | ({63'd0, lg_we[1]} << 1), 64'd2);
      lastd = {dhi, dlo} + (di ? (64'(n - 1) << w) : 64'd0);
      chk("R6 last destination address", lg_addr[2*n - 1], lastd);
      rd(6'(8*c), d); chk("R8 control after completion", 64'(d), 64'(ctrl & 32'h7FFF_FFFF));
      rd(6'h20, d); chk("R8 status bit per channel", 64'(d), 64'(32'h8000_0000 >> c));
      wr(6'h20, 32'hFFFF_FFFF);
    end

    summary();
    $finish;
  end
endmodule